// File: doc/BRIEF.md
# Programmable Galois Sequence and CRC Generator

This block is a clocked shift register with programmable feedback in modular (Galois) form. It runs in one of two modes. In pseudo-random mode it steps through a maximal-length sequence when given a suitable polynomial. In CRC mode it folds one serial data bit into a running checksum on each enabled clock. The register width is `SLICE_W * N_SLICES`. It is built from identical 8-bit slices, and the shift carry and polynomial bits ripple from each slice into the one above it.

Software programs a polynomial with one bit per tap: tap n sits in bit n-1. The highest set bit marks the top stage, which is the feedback source. Software then loads a seed and raises `enable`. Turning a simple-format tap list into this encoding is done before the value is written: keep the top tap and replace every other tap t with (top - t). A compare register sits beside the generator. While the state is at or above the compare value, a level output is high. The rising edge of that level is the block's only interrupt.

Top module: `galois_seq_gen`

## Requirements
- R1: One clock edge with `rst_n` low clears the state to 0 and sets the compare register to all ones. After that edge `cmp_ge` and `irq` are both 0.
- R2: A cycle with `seed_we` high loads the seed into the state at the next edge. This happens whatever `enable` is, and it takes priority over a shift in the same cycle.
- R3: With `mode_crc`=0 (pseudo-random), a seed of 0 is loaded as 1. With `mode_crc`=1 (CRC), a seed of 0 is loaded as 0.
- R4: Let h be the index of the highest set polynomial bit. Let fb be bit h of the state, XOR-ed with `din` in CRC mode. Each enabled step then sets bit 0 to fb, sets bit i (1 <= i <= h) to old bit i-1 XOR (fb AND poly bit i-1), and clears every bit above h. A zero polynomial steps the state to 0.
- R5: Tap n of the polynomial is bit n-1. The tap set {7,5,3,1} is 0x0055. In pseudo-random mode with seed 1, it gives 127 distinct nonzero states and then returns to 1.
- R6: In CRC mode the feedback bit is the old top-stage bit XOR `din`, applied in the same cycle's step.
- R7: While `enable` is low and `seed_we` is low, the state holds.
- R8: A polynomial write (`poly_we`) takes effect at the next edge only while `enable` is low. While `enable` is high it is ignored, and the sequence continues under the old polynomial.
- R9: `cmp_ge` is high exactly when the state, read as unsigned, is greater than or equal to the compare register. `cmp_we` loads the compare register at the next edge in any mode.
- R10: `irq` is high for exactly one cycle: the first cycle in which `cmp_ge` is 1 after a cycle in which it was 0. It is the block's only interrupt.
- R11: With the default of two slices (16 bits), feedback, shift carry and polynomial bits cross the slice boundary, so 16-bit polynomials such as 0xC002 step by the R4 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Step the generator on each clock while high |
| mode_crc | input | 1 | 0 = pseudo-random sequence, 1 = CRC |
| din | input | 1 | Serial data bit folded into the feedback in CRC mode |
| poly_we | input | 1 | Polynomial write strobe, honoured only while disabled |
| poly_wdata | input | SLICE_W*N_SLICES | Polynomial value, tap n in bit n-1 |
| seed_we | input | 1 | Seed load strobe |
| seed_wdata | input | SLICE_W*N_SLICES | Seed value |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | SLICE_W*N_SLICES | Compare value |
| state | output | SLICE_W*N_SLICES | Current generator state |
| cmp_ge | output | 1 | State is greater than or equal to the compare value |
| irq | output | 1 | One-cycle pulse on the rising edge of `cmp_ge` |

## Verification
The 7-tap maximal polynomial is run from seed 1 through a full lap. This separates a correct tap-to-bit mapping and feedback position from a mapping off by one stage, because any error shortens the period or repeats a state. A 16-bit polynomial is then run in both modes, with a serial data pattern of mixed runs in CRC mode. This shows whether the shift carry, the polynomial bit and the feedback cross the slice boundary, and whether `din` enters the feedback. Shrinking the polynomial while the state holds high bits exposes any missing clearing above the top stage. Zero seeds in each mode, a seed load during a step, and polynomial writes while enabled and while disabled each tell apart a right and a wrong priority. The compare threshold is moved during a lap so that `cmp_ge` toggles many times, which checks that `irq` fires only on rising edges.

// File: rtl/gsg_pkg.sv
// Shared types for the Galois sequence / CRC generator.
package gsg_pkg;

    // Operating mode: free-running sequence or serial checksum.
    typedef enum logic {
        GSG_PRS = 1'b0,
        GSG_CRC = 1'b1
    } gsg_mode_e;

endpackage

// File: rtl/gsg_tap_locator.sv
// Finds the top stage of a tap-encoded polynomial.
// top_sel: one-hot marker of the highest set polynomial bit (all zero for a zero polynomial).
// keep:    ones at and below that bit; stages above it are cleared on every step.
// Assumes nothing about the polynomial value.
module gsg_tap_locator #(
    parameter int W = 16
) (
    input  logic [W-1:0] poly,
    output logic [W-1:0] keep,
    output logic [W-1:0] top_sel
);

    logic seen;

    // Scan from the MSB down: the first set bit found is the top stage.
    always_comb begin
        seen = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            top_sel[i] = poly[i] & ~seen;
            seen       = seen | poly[i];
            keep[i]    = seen;
        end
    end

endmodule

// File: rtl/gsg_slice.sv
// One slice of the modular shift register: a state byte and its polynomial byte.
// Bit 0 of the slice takes the top bit of the slice below it and that slice's top
// polynomial bit. The lowest slice is fed 0 and 1, so its bit 0 becomes the feedback.
// Assumes SW >= 2 and that fb and keep are computed over the whole register.
module gsg_slice #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          poly_we,
    input  logic [SW-1:0] poly_wdata,
    input  logic          seed_we,
    input  logic [SW-1:0] seed_data,
    input  logic          fb,
    input  logic [SW-1:0] keep,
    input  logic          shift_in,
    input  logic          poly_below,
    output logic [SW-1:0] state_q,
    output logic [SW-1:0] poly_q
);

    logic [SW-1:0] shifted;
    logic [SW-1:0] tap_en;
    logic [SW-1:0] step;

    // Each stage takes the stage below it, XOR-ed with the feedback where tapped.
    always_comb begin
        shifted = {state_q[SW-2:0], shift_in};
        tap_en  = {poly_q[SW-2:0], poly_below};
        step    = keep & (shifted ^ ({SW{fb}} & tap_en));
    end

    // State register: a seed load wins over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= '0;
        else if (seed_we) state_q <= seed_data;
        else if (en)      state_q <= step;
    end

    // Polynomial register: writable only while the generator is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                poly_q <= '0;
        else if (poly_we && !en)   poly_q <= poly_wdata;
    end

    // R8: the polynomial cannot change across a cycle in which the block was enabled.
    assert_poly_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(poly_q));

    // R7: with no step and no seed load the slice holds its state.
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_we) |=> $stable(state_q));

endmodule

// File: rtl/gsg_compare.sv
// Compare register and interrupt edge detector.
// cmp_ge is a level computed from registered values; irq is high in the first cycle
// that level is set after a cycle in which it was clear.
// Assumes state is the registered generator state.
module gsg_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [W-1:0] state,
    output logic         cmp_ge,
    output logic         irq
);

    logic [W-1:0] cmp_q;
    logic         ge_d;

    // Compare register: all ones after reset so the level starts clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // Unsigned threshold level.
    always_comb cmp_ge = (state >= cmp_q);

    // Previous-cycle copy of the level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ge_d <= 1'b0;
        else        ge_d <= cmp_ge;
    end

    // Interrupt on the rising edge of the level.
    always_comb irq = cmp_ge & ~ge_d;

    // R9: a compare write lands on the next edge.
    assert_cmp_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> (cmp_q == $past(cmp_wdata)));

    // R10: the interrupt is never longer than one cycle.
    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: the interrupt only accompanies a set level.
    assert_irq_with_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cmp_ge);

endmodule

// File: rtl/galois_seq_gen.sv
// Programmable modular LFSR / CRC generator built from SLICE_W-bit slices.
// Tap n of the polynomial is bit n-1; the highest set bit is the feedback stage.
// In CRC mode the feedback is XOR-ed with din. A zero seed in sequence mode loads as 1.
// Assumes SLICE_W >= 2 and N_SLICES >= 1.
module galois_seq_gen
    import gsg_pkg::*;
#(
    parameter int SLICE_W  = 8,
    parameter int N_SLICES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enable,
    input  logic                          mode_crc,
    input  logic                          din,
    input  logic                          poly_we,
    input  logic [SLICE_W*N_SLICES-1:0]   poly_wdata,
    input  logic                          seed_we,
    input  logic [SLICE_W*N_SLICES-1:0]   seed_wdata,
    input  logic                          cmp_we,
    input  logic [SLICE_W*N_SLICES-1:0]   cmp_wdata,
    output logic [SLICE_W*N_SLICES-1:0]   state,
    output logic                          cmp_ge,
    output logic                          irq
);

    localparam int W = SLICE_W * N_SLICES;

    gsg_mode_e    mode;
    logic [W-1:0] state_q;
    logic [W-1:0] poly_q;
    logic [W-1:0] keep;
    logic [W-1:0] top_sel;
    logic [W-1:0] seed_eff;
    logic         fb;

    // Decode the mode pin into the shared enum.
    always_comb mode = gsg_mode_e'(mode_crc);

    // Replace a zero seed with 1 in sequence mode so the lock-up state is never entered.
    always_comb seed_eff = ((mode == GSG_PRS) && (seed_wdata == '0)) ? W'(1) : seed_wdata;

    // Feedback: the top-stage bit, folded with serial data in CRC mode.
    always_comb fb = (|(state_q & top_sel)) ^ ((mode == GSG_CRC) & din);

    gsg_tap_locator #(.W(W)) u_locator (
        .poly    (poly_q),
        .keep    (keep),
        .top_sel (top_sel)
    );

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        logic sh_in;
        logic p_in;
        if (s == 0) begin : g_low
            assign sh_in = 1'b0;
            assign p_in  = 1'b1;
        end else begin : g_up
            assign sh_in = state_q[s*SLICE_W-1];
            assign p_in  = poly_q[s*SLICE_W-1];
        end

        gsg_slice #(.SW(SLICE_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (enable),
            .poly_we    (poly_we),
            .poly_wdata (poly_wdata[s*SLICE_W +: SLICE_W]),
            .seed_we    (seed_we),
            .seed_data  (seed_eff[s*SLICE_W +: SLICE_W]),
            .fb         (fb),
            .keep       (keep[s*SLICE_W +: SLICE_W]),
            .shift_in   (sh_in),
            .poly_below (p_in),
            .state_q    (state_q[s*SLICE_W +: SLICE_W]),
            .poly_q     (poly_q[s*SLICE_W +: SLICE_W])
        );
    end

    gsg_compare #(.W(W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_we    (cmp_we),
        .cmp_wdata (cmp_wdata),
        .state     (state_q),
        .cmp_ge    (cmp_ge),
        .irq       (irq)
    );

    // Drive the state port from the slice registers.
    always_comb state = state_q;

    // R3: a zero seed in sequence mode arrives as 1.
    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && !mode_crc && (seed_wdata == '0)) |=> (state == W'(1)));

    // R2: any other seed arrives unchanged, whatever enable was.
    assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && (mode_crc || (seed_wdata != '0))) |=> (state == $past(seed_wdata)));

endmodule

// File: tb/tb_galois_seq_gen.sv
module tb_galois_seq_gen;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         enable;
    logic         mode_crc;
    logic         din;
    logic         poly_we;
    logic [W-1:0] poly_wdata;
    logic         seed_we;
    logic [W-1:0] seed_wdata;
    logic         cmp_we;
    logic [W-1:0] cmp_wdata;
    logic [W-1:0] state;
    logic         cmp_ge;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string tag = "R1";

    // behavioural model
    int unsigned m_state, m_poly, m_cmp;
    bit          m_ge_prev;

    always #10 clk = ~clk;

    galois_seq_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_crc(mode_crc), .din(din),
        .poly_we(poly_we), .poly_wdata(poly_wdata), .seed_we(seed_we),
        .seed_wdata(seed_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .state(state), .cmp_ge(cmp_ge), .irq(irq)
    );

    function automatic int unsigned model_step(int unsigned s, int unsigned p, bit d, bit crc);
        int h = -1;
        int unsigned mask, n;
        bit f;
        for (int i = 0; i < W; i++) if (((p >> i) & 1) == 1) h = i;
        if (h < 0) return 0;
        f    = bit'((s >> h) & 1) ^ (crc & d);
        mask = ((p & ((32'd1 << h) - 1)) << 1) | 1;
        n    = (s << 1) & ((32'd1 << (h + 1)) - 1);
        if (f) n = n ^ mask;
        return n;
    endfunction

    task automatic chk(bit ok, string req, int unsigned act, int unsigned exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic tick();
        bit ge_now;
        @(posedge clk);
        if (!rst_n) begin
            m_state = 0; m_poly = 0; m_cmp = 32'hFFFF; m_ge_prev = 0;
        end else begin
            m_ge_prev = (m_state >= m_cmp);
            if (seed_we)
                m_state = (!mode_crc && seed_wdata == 0) ? 1 : int'(seed_wdata);
            else if (enable)
                m_state = model_step(m_state, m_poly, din, mode_crc);
            if (poly_we && !enable) m_poly = poly_wdata;
            if (cmp_we) m_cmp = cmp_wdata;
        end
        @(negedge clk);
        ge_now = (m_state >= m_cmp);
        chk(state == W'(m_state), tag, state, m_state, "state");
        chk(cmp_ge == ge_now, "R9", cmp_ge, ge_now, "cmp_ge");
        chk(irq == (ge_now & ~m_ge_prev), "R10", irq, ge_now & ~m_ge_prev, "irq");
    endtask

    task automatic set_poly(int unsigned p);
        poly_we = 1; poly_wdata = W'(p); tick(); poly_we = 0;
    endtask

    task automatic set_seed(int unsigned s);
        seed_we = 1; seed_wdata = W'(s); tick(); seed_we = 0;
    endtask

    task automatic set_cmp(int unsigned c);
        cmp_we = 1; cmp_wdata = W'(c); tick(); cmp_we = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen [0:255];
        int period, distinct, irq_cnt;
        bit zero_hit;
        int unsigned held;

        rst_n = 0; enable = 0; mode_crc = 0; din = 0;
        poly_we = 0; poly_wdata = '0; seed_we = 0; seed_wdata = '0;
        cmp_we = 0; cmp_wdata = '0;
        repeat (3) tick();
        tag = "R1";
        chk(state == 0 && cmp_ge == 0 && irq == 0, "R1", {state, cmp_ge, irq}, 0, "reset outputs");
        rst_n = 1;
        tick();

        // R8 accepted while disabled, R2 seed load, R5 maximal lap
        tag = "R8";
        set_poly(32'h0055);
        tag = "R2";
        set_seed(1);
        chk(state == 1, "R2", state, 1, "seed while disabled");
        set_cmp(32'h0040);
        tag = "R4";
        enable = 1;
        foreach (seen[i]) seen[i] = 0;
        period = 0; distinct = 0; zero_hit = 0; irq_cnt = 0;
        for (int k = 0; k < 200; k++) begin
            tick();
            period++;
            if (irq) irq_cnt++;
            if (state == 0) zero_hit = 1;
            if (state < 256 && !seen[state[7:0]]) begin seen[state[7:0]] = 1; distinct++; end
            if (state == 1) break;
        end
        chk(period == 127, "R5", period, 127, "period of 0x0055");
        chk(distinct == 127, "R5", distinct, 127, "distinct states");
        chk(!zero_hit, "R5", zero_hit, 0, "zero state reached");
        chk(irq_cnt > 0, "R10", irq_cnt, 1, "irq pulses during lap");

        // R9 threshold moved while running
        tag = "R9";
        set_cmp(32'h0010);
        repeat (20) tick();

        // R8 write while enabled is ignored
        tag = "R8";
        set_poly(32'hC002);
        repeat (30) tick();

        // R7 hold while disabled
        tag = "R7";
        enable = 0;
        tick();
        held = state;
        repeat (5) tick();
        chk(state == W'(held), "R7", state, held, "held state");

        // R2 seed wins over a step
        tag = "R2";
        enable = 1;
        set_seed(32'h0021);
        chk(state == 16'h0021, "R2", state, 16'h0021, "seed during step");
        enable = 0;

        // R3 zero seeds in each mode
        tag = "R3";
        set_seed(0);
        chk(state == 1, "R3", state, 1, "zero seed PRS");
        mode_crc = 1;
        set_seed(0);
        chk(state == 0, "R3", state, 0, "zero seed CRC");

        // R11 16-bit polynomial in PRS mode, crosses the slice boundary
        tag = "R11";
        mode_crc = 0;
        set_poly(32'hC002);
        set_seed(32'h00F3);
        enable = 1;
        repeat (60) tick();

        // R4 shrink polynomial while high bits are set: bits above the top stage clear
        tag = "R4";
        enable = 0;
        set_seed(32'hF0F1);
        set_poly(32'h0009);
        enable = 1;
        tick();
        chk(state[W-1:4] == 0, "R4", state, state & 16'h000F, "bits above top cleared");
        repeat (20) tick();

        // R6 CRC mode with a serial pattern
        tag = "R6";
        enable = 0;
        mode_crc = 1;
        set_poly(32'hC002);
        set_seed(32'hFFFF);
        enable = 1;
        for (int k = 0; k < 48; k++) begin
            din = ((k % 7) < 3) ^ (k[2]);
            tick();
        end
        din = 0;
        enable = 0;
        tick();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule